// File: doc/BRIEF.md
# Synchronized Multi-Channel Capture Group

This block lets several measurement channels take a snapshot of their counters on one and the same system clock, and it starts that snapshot from a single edge on an external trigger input. Software arms a chosen set of channels with one strobe and a channel mask. The first rising trigger edge that follows then latches the live counter value of every armed channel at once. Each latched value is held, and trigger edges that come later are ignored until software arms the group again. Values therefore always belong together and are never overwritten by a later event.

Each channel has a done flag that rises when its value is latched and falls when software reads that channel. A group flag reports that the armed set has been captured and stays up until the next arm command. Arming again while a captured value is still unread throws away the held values of the newly armed channels and sets a sticky overrun flag. The counters are outside the block and are seen as free-running inputs on a flat bus, with channel i in bits [i*CNT_W +: CNT_W].

Top module: `sync_capture_group`

## Requirements
- R1: After reset every held value is zero, and every done flag, the group flag and the overrun flag are low.
- R2: An arm strobe arms every channel whose mask bit is one on the same clock, clears their done flags and held values, and clears the group flag; arming alone never sets a done flag.
- R3: The first trigger rise after arming latches all armed channels on one clock: the held value is the counter value present at the third rising clock edge after the trigger input goes high (two synchronizer stages plus the edge detector), and the done flags rise at that same edge, not earlier.
- R4: Trigger edges that arrive after a capture and before the next arm strobe leave every held value and done flag unchanged.
- R5: A read strobe on channel i clears done flag i at the next clock edge and leaves the held value of channel i unchanged.
- R6: The group flag rises on the clock that latches the armed channels and stays high through reads until the next arm strobe clears it.
- R7: An arm strobe while any done flag is still high sets the overrun flag, which then stays high until reset.
- R8: A channel whose mask bit is zero at an arm strobe is disarmed, keeps its held value and done flag, and is not captured by the following trigger edge.
- R9: A trigger rise while no channel is armed changes no held value and no flag.
- R10: Only a low-to-high transition of the trigger captures: a trigger already high when the group is armed causes no capture until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_strobe | input | 1 | One-cycle arm command for the group |
| arm_mask | input | NUM_CH | Channels to arm, sampled with arm_strobe |
| trig_in | input | 1 | Asynchronous external trigger |
| cnt_live | input | NUM_CH*CNT_W | Free-running counter of each channel, flat |
| rd_strobe | input | NUM_CH | Per-channel read acknowledge |
| held_val | output | NUM_CH*CNT_W | Latched value of each channel, flat |
| chan_done | output | NUM_CH | Per-channel capture-done flag |
| group_done | output | 1 | Armed set has been captured |
| overrun | output | 1 | Sticky: re-armed over an unread capture |

## Verification
On every cycle the assertions check that held values move only on an arm strobe or a fresh capture, that new done flags always coincide with the group flag, that an arm clears the masked flags and the group flag, that reads clear done flags, and that the group and overrun flags hold their state. The bench scenarios are needed to show the captured values themselves and their exact three-clock latency, that extra trigger edges and edges with nothing armed are ignored, that unmasked channels keep their old data, and that a trigger which is already high does not count as an edge.

// File: rtl/scg_pkg.sv
// Package: shared defaults for the synchronized capture group.
// Assumes: every module of the group imports these defaults.
package scg_pkg;
    parameter int unsigned SCG_DEF_CH     = 4;
    parameter int unsigned SCG_DEF_CNT_W  = 16;
    parameter int unsigned SCG_SYNC_DEPTH = 2;
endpackage

// File: rtl/scg_trig_sync.sv
// Trigger synchronizer and rising-edge detector.
// Assumes trig_in is asynchronous to clk; edge_o is a one-cycle pulse
// that appears combinationally after the last synchronizer stage.
module scg_trig_sync
    import scg_pkg::*;
#(
    parameter int unsigned STAGES = SCG_SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic edge_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw trigger through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_in};
        end
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // A rise is a high synchronized level that was low one cycle before.
    always_comb begin
        edge_o = sync_q[LAST] & ~prev_q;
    end
endmodule

// File: rtl/scg_channel.sv
// One capture channel: arm flag, done flag and held value.
// Assumes cap_fire is a single-cycle pulse shared by all channels and
// that an arm strobe takes priority over a capture in the same cycle.
module scg_channel
    import scg_pkg::*;
#(
    parameter int unsigned CNT_W = SCG_DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_stb,
    input  logic             arm_sel,
    input  logic             cap_fire,
    input  logic             rd_stb,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] held_o,
    output logic             done_o,
    output logic             armed_o
);
    logic [CNT_W-1:0] held_q;
    logic             done_q;
    logic             armed_q;

    // Arm, capture and read-acknowledge state of this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (arm_stb) begin
            armed_q <= arm_sel;
            if (arm_sel) begin
                done_q <= 1'b0;
                held_q <= '0;
            end else if (rd_stb) begin
                done_q <= 1'b0;
            end
        end else if (cap_fire && armed_q) begin
            held_q  <= cnt_in;
            done_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (rd_stb) begin
            done_q <= 1'b0;
        end
    end

    // Drive the outputs straight from the state.
    always_comb begin
        held_o  = held_q;
        done_o  = done_q;
        armed_o = armed_q;
    end
endmodule

// File: rtl/scg_group_ctrl.sv
// Group control: decides when the shared capture fires and keeps the
// group-done and sticky overrun flags.
// Assumes armed_i and done_i come from the channel registers.
module scg_group_ctrl
    import scg_pkg::*;
#(
    parameter int unsigned NUM_CH = SCG_DEF_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_stb,
    input  logic              trig_edge,
    input  logic [NUM_CH-1:0] armed_i,
    input  logic [NUM_CH-1:0] done_i,
    output logic              cap_fire,
    output logic              group_done,
    output logic              overrun
);
    logic grp_q;
    logic ovr_q;

    // Fire on a detected edge when something is armed and no arm is in flight.
    always_comb begin
        cap_fire = trig_edge & (|armed_i) & ~arm_stb;
    end

    // Group flag: cleared by arming, set by the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= 1'b0;
        end else if (arm_stb) begin
            grp_q <= 1'b0;
        end else if (cap_fire) begin
            grp_q <= 1'b1;
        end
    end

    // Overrun flag: set when arming over an unread capture, kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (arm_stb && (|done_i)) begin
            ovr_q <= 1'b1;
        end
    end

    // Drive the outputs.
    always_comb begin
        group_done = grp_q;
        overrun    = ovr_q;
    end
endmodule

// File: rtl/sync_capture_group.sv
// Top of the synchronized capture group: one trigger synchronizer, one
// group controller and NUM_CH channels that all latch on the same clock.
// Assumes counters are presented on a flat bus, channel i at i*CNT_W.
module sync_capture_group
    import scg_pkg::*;
#(
    parameter int unsigned NUM_CH = SCG_DEF_CH,
    parameter int unsigned CNT_W  = SCG_DEF_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arm_strobe,
    input  logic [NUM_CH-1:0]       arm_mask,
    input  logic                    trig_in,
    input  logic [NUM_CH*CNT_W-1:0] cnt_live,
    input  logic [NUM_CH-1:0]       rd_strobe,
    output logic [NUM_CH*CNT_W-1:0] held_val,
    output logic [NUM_CH-1:0]       chan_done,
    output logic                    group_done,
    output logic                    overrun
);
    logic              trig_edge;
    logic              cap_fire;
    logic [NUM_CH-1:0] armed_vec;

    scg_trig_sync #(
        .STAGES (SCG_SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .edge_o  (trig_edge)
    );

    scg_group_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_stb    (arm_strobe),
        .trig_edge  (trig_edge),
        .armed_i    (armed_vec),
        .done_i     (chan_done),
        .cap_fire   (cap_fire),
        .group_done (group_done),
        .overrun    (overrun)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        scg_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_stb  (arm_strobe),
            .arm_sel  (arm_mask[gi]),
            .cap_fire (cap_fire),
            .rd_stb   (rd_strobe[gi]),
            .cnt_in   (cnt_live[gi*CNT_W +: CNT_W]),
            .held_o   (held_val[gi*CNT_W +: CNT_W]),
            .done_o   (chan_done[gi]),
            .armed_o  (armed_vec[gi])
        );
    end
endmodule

// File: rtl/scg_checker.sv
// Checker for the capture group, attached to every instance by bind.
// Observes ports only; all properties are disabled during reset.
module scg_checker #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    arm_strobe,
    input logic [NUM_CH-1:0]       arm_mask,
    input logic [NUM_CH-1:0]       rd_strobe,
    input logic [NUM_CH*CNT_W-1:0] held_val,
    input logic [NUM_CH-1:0]       chan_done,
    input logic                    group_done,
    input logic                    overrun
);
    // R2: arming clears masked done flags and the group flag.
    p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_strobe |=> (((chan_done & $past(arm_mask)) == '0) && !group_done));

    // R4: held values move only on an arm or together with a fresh done flag.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held_val) |-> ($past(arm_strobe) || ((chan_done & ~$past(chan_done)) != '0)));

    // R5: a read of a done channel clears its flag.
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_strobe & chan_done) != '0) |=> (($past(rd_strobe & chan_done) & chan_done) == '0));

    // R6: any newly raised done flag comes with the group flag.
    p_grp_on_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_done & ~$past(chan_done)) != '0) |-> group_done);

    // R6: the group flag holds until an arm strobe.
    p_grp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (group_done && !arm_strobe) |=> group_done);

    // R7: overrun is sticky.
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind sync_capture_group scg_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_scg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_strobe (arm_strobe),
    .arm_mask   (arm_mask),
    .rd_strobe  (rd_strobe),
    .held_val   (held_val),
    .chan_done  (chan_done),
    .group_done (group_done),
    .overrun    (overrun)
);

// File: tb/sync_capture_group_bench.sv
// Directed bench for the synchronized capture group.
module sync_capture_group_bench;
    localparam int unsigned NUM_CH = 4;
    localparam int unsigned CNT_W  = 16;
    localparam time         CLK_PERIOD = 10ns;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    arm_strobe = 1'b0;
    logic [NUM_CH-1:0]       arm_mask = '0;
    logic                    trig_in = 1'b0;
    logic [NUM_CH*CNT_W-1:0] cnt_live;
    logic [NUM_CH-1:0]       rd_strobe = '0;
    logic [NUM_CH*CNT_W-1:0] held_val;
    logic [NUM_CH-1:0]       chan_done;
    logic                    group_done;
    logic                    overrun;

    int unsigned cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    logic [CNT_W-1:0]  exp_held [NUM_CH];
    logic [NUM_CH-1:0] exp_done  = '0;
    logic [NUM_CH-1:0] exp_armed = '0;
    logic              exp_grp   = 1'b0;
    logic              exp_ovr   = 1'b0;

    sync_capture_group #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_sync_capture_group (
        .clk(clk), .rst_n(rst_n), .arm_strobe(arm_strobe), .arm_mask(arm_mask),
        .trig_in(trig_in), .cnt_live(cnt_live), .rd_strobe(rd_strobe),
        .held_val(held_val), .chan_done(chan_done), .group_done(group_done),
        .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running counters change shortly after each rising edge.
    always @(posedge clk) begin
        #2 cyc = cyc + 1;
    end

    function automatic logic [CNT_W-1:0] cnt_of(int unsigned c, int ch);
        return CNT_W'(c * (ch + 1) + 100 * ch);
    endfunction

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cnt
        assign cnt_live[gi*CNT_W +: CNT_W] = cnt_of(cyc, gi);
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        for (int i = 0; i < NUM_CH; i++)
            chk(req, $sformatf("held[%0d]", i), held_val[i*CNT_W +: CNT_W], exp_held[i]);
        chk(req, "chan_done", chan_done, exp_done);
        chk(req, "group_done", group_done, exp_grp);
        chk(req, "overrun", overrun, exp_ovr);
    endtask

    task automatic do_arm(logic [NUM_CH-1:0] m);
        @(negedge clk);
        arm_strobe = 1'b1;
        arm_mask   = m;
        @(negedge clk);
        arm_strobe = 1'b0;
        arm_mask   = '0;
        if (exp_done != '0) exp_ovr = 1'b1;
        for (int i = 0; i < NUM_CH; i++)
            if (m[i]) begin exp_held[i] = '0; exp_done[i] = 1'b0; end
        exp_armed = m;
        exp_grp   = 1'b0;
    endtask

    task automatic do_read(logic [NUM_CH-1:0] m);
        @(negedge clk);
        rd_strobe = m;
        @(negedge clk);
        rd_strobe = '0;
        exp_done = exp_done & ~m;
    endtask

    // Raise the trigger and check the capture three clock edges later.
    task automatic trig_rise(string req);
        int unsigned c;
        @(negedge clk);
        trig_in = 1'b1;
        c = cyc;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({req, " latency"}, "chan_done", chan_done, exp_done);
        @(posedge clk);
        @(negedge clk);
        if (exp_armed != '0) begin
            for (int i = 0; i < NUM_CH; i++)
                if (exp_armed[i]) begin
                    exp_held[i] = cnt_of(c + 2, i);
                    exp_done[i] = 1'b1;
                end
            exp_armed = '0;
            exp_grp   = 1'b1;
        end
        chk_all(req);
    endtask

    task automatic trig_fall();
        @(negedge clk);
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NUM_CH; i++) exp_held[i] = '0;
        @(negedge clk);
        chk_all("R1");
    endtask

    task automatic t_no_arm_edge();
        trig_rise("R9");
        trig_fall();
        chk_all("R9");
    endtask

    task automatic t_basic_capture();
        do_arm('1);
        repeat (3) @(negedge clk);
        chk_all("R2");
        trig_rise("R3");
        chk("R6", "group_done", group_done, 1'b1);
        trig_fall();
    endtask

    task automatic t_ignore_later();
        trig_rise("R4");
        trig_fall();
        trig_rise("R4");
        trig_fall();
        chk_all("R4");
    endtask

    task automatic t_reads();
        do_read(4'b0101);
        chk_all("R5");
        do_read(4'b1010);
        chk_all("R5");
        chk("R6", "group_done", group_done, 1'b1);
    endtask

    task automatic t_partial_mask();
        do_arm(4'b0101);
        chk_all("R8");
        trig_rise("R8");
        trig_fall();
    endtask

    task automatic t_overrun();
        do_arm(4'b0011);
        chk_all("R7");
        trig_rise("R7");
        trig_fall();
        chk("R7", "overrun", overrun, 1'b1);
    endtask

    task automatic t_level_high();
        do_read('1);
        trig_rise("R10");
        do_arm('1);
        repeat (5) @(negedge clk);
        chk_all("R10");
        trig_fall();
        trig_rise("R10");
        trig_fall();
    endtask

    initial begin
        t_reset();
        t_no_arm_edge();
        t_basic_capture();
        t_ignore_later();
        t_reads();
        t_partial_mask();
        t_overrun();
        t_level_high();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule